// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a direct-mapped data cache paired with a small fully associative buffer of recently evicted lines. A request from the processor is first looked up in the direct-mapped array. A hit there answers at once. On a miss, the buffer of evicted lines is searched in the next cycle, before anything is sent to the next memory level. When the buffer holds the line, it trades places with the line in the indexed set of the main array, and no memory traffic takes place.

When both stores miss, the line is fetched from a simple next-level memory over a valid/ready request channel and a one-beat response. The refilled line goes into the main array. The line it displaces moves into the evicted-line buffer. The buffer fills its slots in strict rotation. A dirty line that leaves the buffer is written to memory before its slot is reused.

Every line holds one data word and is addressed by word. Each answer carries exactly one of three status flags: fast hit, slow hit (found in the evicted-line buffer) or miss.

Top module: `vcache_top`

## Requirements
- R1: After reset, `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, and every line in both stores is invalid, so the first access to any address is a miss.
- R2: A request accepted (`req_valid` and `req_ready` both high at a clock edge) that hits the main array gives `rsp_valid` with `stat_hit` in the very next cycle and issues no memory request.
- R3: A request that misses the main array causes no response and no memory request in the next cycle while the evicted-line buffer is searched. A hit in the buffer answers with `stat_slow_hit` two cycles after acceptance and issues no memory request.
- R4: On a slow hit, the requested line moves into the main array and the line that was there moves into the matching buffer slot. Each address is held in at most one place, so a later access to the displaced line is itself a slow hit.
- R5: When both stores miss, exactly one memory read of the requested address is issued (`mem_req_write` = 0). The answer carries `stat_miss` in the cycle after `mem_rsp_valid`, and the refilled line stays in the main array.
- R6: The buffer holds `VICTIMS` lines (4 by default). A line displaced by a refill is inserted into slots in round-robin order, replacing the slot that received an insertion longest ago.
- R7: When the slot about to take an insertion holds a dirty line, that line is written to memory (`mem_req_write` = 1, with its own address and data) before the read for the miss is issued. A clean line is dropped without memory traffic.
- R8: A memory request keeps `mem_req_valid`, `mem_req_addr`, `mem_req_write` and `mem_req_wdata` unchanged until a cycle with `mem_req_ready` high.
- R9: `rsp_valid` is high for one cycle per accepted request, with exactly one of `stat_hit`, `stat_slow_hit` and `stat_miss` set. When `rsp_valid` is low, all three flags are low.
- R10: Writes allocate on a miss and mark the line dirty. `rsp_rdata` returns the line's data after the access: the written word for a write and the stored word for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_rdata | output | DATA_W | Line data after the access |
| stat_hit | output | 1 | Answer came from the main array |
| stat_slow_hit | output | 1 | Answer came from the evicted-line buffer |
| stat_miss | output | 1 | Answer needed a memory read |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write-back, 0 = line read |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Write-back data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | DATA_W | Read data |

## Verification
The embedded assertions check on every cycle the following properties:
- the one-cycle answer of a main-array hit;
- the silent search cycle that follows a main-array miss;
- the one-hot status flags;
- memory requests held stable until accepted;
- the write-back of a dirty slot before the refill read;
- at most one matching slot in the buffer;
- insertions landing only in the rotation slot.

Only the bench's scenarios can show the rest, because a behavioural model must track contents over many accesses. This covers:
- which data each answer returns;
- that swapped lines really trade places;
- the round-robin order of replacement;
- that a written line survives eviction, write-back and a later refill.

// File: rtl/vc_pkg.sv
// Package: shared types for the victim-buffered data cache.
// Assumes: nothing beyond IEEE 1800-2017.
package vc_pkg;

    // Controller states of the cache access sequencer
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // accepting requests, main lookup
        ST_VSRCH = 3'd1,   // searching the evicted-line buffer
        ST_WB    = 3'd2,   // writing a dirty buffer slot to memory
        ST_RD    = 3'd3,   // issuing the line read
        ST_WAIT  = 3'd4    // waiting for read data
    } vc_state_e;

endpackage

// File: rtl/vc_main_array.sv
// Module: direct-mapped tag/data store with one combinational lookup port
// and one synchronous write port. Lines hold a single word.
// Assumes: SETS is a power of two; a written line is always made valid.
module vc_main_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int SETS   = 8,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_valid,
    output logic              lk_dirty,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_dirty
);

    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    // Status bits: cleared by reset, set on every line write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    // Tag and data payload, no reset needed
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign lk_valid = valid_q[lk_idx];
    assign lk_dirty = dirty_q[lk_idx];
    assign lk_tag   = tag_q[lk_idx];
    assign lk_data  = data_q[lk_idx];

endmodule

// File: rtl/vc_victim_store.sv
// Module: small fully associative store of evicted lines, tagged by full
// word address. It provides a parallel search, a view of the rotation slot
// and one write port. The rotation pointer advances only on insertion.
// Assumes: the controller never writes an address already present elsewhere.
module vc_victim_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int WAYS   = 4,
    localparam int SLOT_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] srch_addr,
    output logic              srch_hit,
    output logic [SLOT_W-1:0] srch_slot,
    output logic [DATA_W-1:0] srch_data,
    output logic              srch_dirty,
    output logic [SLOT_W-1:0] ptr_slot,
    output logic              ptr_valid,
    output logic              ptr_dirty,
    output logic [ADDR_W-1:0] ptr_addr,
    output logic [DATA_W-1:0] ptr_data,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_dirty,
    input  logic              ptr_adv
);

    logic [WAYS-1:0]   valid_q;
    logic [WAYS-1:0]   dirty_q;
    logic [ADDR_W-1:0] addr_q [WAYS];
    logic [DATA_W-1:0] data_q [WAYS];
    logic [SLOT_W-1:0] ptr_q;
    logic [WAYS-1:0]   match;

    // One comparator per slot
    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_cmp
            assign match[g] = valid_q[g] && (addr_q[g] == srch_addr);
        end
    endgenerate

    // Encode the matching slot and its contents
    always_comb begin
        srch_slot  = '0;
        srch_data  = '0;
        srch_dirty = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            if (match[i]) begin
                srch_slot  = SLOT_W'(i);
                srch_data  = data_q[i];
                srch_dirty = dirty_q[i];
            end
        end
    end
    assign srch_hit = |match;

    // Slot status bits and the rotation pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            ptr_q   <= '0;
        end else begin
            if (wr_en) begin
                valid_q[wr_slot] <= wr_valid;
                dirty_q[wr_slot] <= wr_dirty;
            end
            if (ptr_adv) begin
                ptr_q <= (ptr_q == SLOT_W'(WAYS - 1)) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    // Slot payload
    always_ff @(posedge clk) begin
        if (wr_en) begin
            addr_q[wr_slot] <= wr_addr;
            data_q[wr_slot] <= wr_data;
        end
    end

    assign ptr_slot  = ptr_q;
    assign ptr_valid = valid_q[ptr_q];
    assign ptr_dirty = dirty_q[ptr_q];
    assign ptr_addr  = addr_q[ptr_q];
    assign ptr_data  = data_q[ptr_q];

    // An address never sits in two slots at once
    assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // An insertion always lands in the rotation slot
    assert_insert_at_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_adv |-> (wr_en && wr_slot == ptr_q));

endmodule

// File: rtl/vcache_top.sv
// Module: direct-mapped data cache with an evicted-line buffer beside it.
// It looks up the main array in the accept cycle, searches the buffer in the
// next cycle on a miss, swaps on a buffer hit, and otherwise writes back a
// dirty rotation slot, reads the line and refills.
// Assumes: memory answers a read at least one cycle after accepting it.
module vcache_top
    import vc_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32,
    parameter int SETS    = 8,
    parameter int VICTIMS = 4,
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - IDX_W,
    localparam int SLOT_W = (VICTIMS > 1) ? $clog2(VICTIMS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              stat_hit,
    output logic              stat_slow_hit,
    output logic              stat_miss,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);

    vc_state_e         state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wb_done_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic              accept, main_hit;

    logic              m_valid, m_dirty;
    logic [TAG_W-1:0]  m_tag;
    logic [DATA_W-1:0] m_data;

    logic              v_hit, v_dirty, v_ptr_valid, v_ptr_dirty;
    logic [SLOT_W-1:0] v_slot, v_ptr_slot;
    logic [DATA_W-1:0] v_data, v_ptr_data;
    logic [ADDR_W-1:0] v_ptr_addr;

    logic              mw_en, mw_dirty;
    logic [DATA_W-1:0] mw_data;
    logic              vw_en, vw_adv;
    logic [SLOT_W-1:0] vw_slot;

    // The accept cycle looks up the live address, later states the latched one
    assign cur_addr  = (state_q == ST_IDLE) ? req_addr : addr_q;
    assign cur_idx   = cur_addr[IDX_W-1:0];
    assign cur_tag   = cur_addr[ADDR_W-1:IDX_W];
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign main_hit  = m_valid && (m_tag == cur_tag);

    vc_main_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (cur_idx),
        .lk_valid (m_valid),
        .lk_dirty (m_dirty),
        .lk_tag   (m_tag),
        .lk_data  (m_data),
        .wr_en    (mw_en),
        .wr_idx   (cur_idx),
        .wr_tag   (cur_tag),
        .wr_data  (mw_data),
        .wr_dirty (mw_dirty)
    );

    vc_victim_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(VICTIMS)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .srch_addr  (addr_q),
        .srch_hit   (v_hit),
        .srch_slot  (v_slot),
        .srch_data  (v_data),
        .srch_dirty (v_dirty),
        .ptr_slot   (v_ptr_slot),
        .ptr_valid  (v_ptr_valid),
        .ptr_dirty  (v_ptr_dirty),
        .ptr_addr   (v_ptr_addr),
        .ptr_data   (v_ptr_data),
        .wr_en      (vw_en),
        .wr_slot    (vw_slot),
        .wr_valid   (m_valid),
        .wr_addr    ({m_tag, cur_idx}),
        .wr_data    (m_data),
        .wr_dirty   (m_dirty),
        .ptr_adv    (vw_adv)
    );

    // Line moves: write hit, swap on slow hit, refill plus insertion on miss
    always_comb begin
        mw_en    = 1'b0;
        mw_data  = m_data;
        mw_dirty = m_dirty;
        vw_en    = 1'b0;
        vw_slot  = v_ptr_slot;
        vw_adv   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept && main_hit && req_write) begin
                    mw_en    = 1'b1;
                    mw_data  = req_wdata;
                    mw_dirty = 1'b1;
                end
            end
            ST_VSRCH: begin
                if (v_hit) begin
                    mw_en    = 1'b1;
                    mw_data  = write_q ? wdata_q : v_data;
                    mw_dirty = v_dirty | write_q;
                    vw_en    = 1'b1;
                    vw_slot  = v_slot;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    mw_en    = 1'b1;
                    mw_data  = write_q ? wdata_q : mem_rsp_rdata;
                    mw_dirty = write_q;
                    vw_en    = m_valid;
                    vw_adv   = m_valid;
                end
            end
            default: ;
        endcase
    end

    // Access sequencer and registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            addr_q        <= '0;
            write_q       <= 1'b0;
            wdata_q       <= '0;
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            stat_hit      <= 1'b0;
            stat_slow_hit <= 1'b0;
            stat_miss     <= 1'b0;
        end else begin
            rsp_valid     <= 1'b0;
            stat_hit      <= 1'b0;
            stat_slow_hit <= 1'b0;
            stat_miss     <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q  <= req_addr;
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                        if (main_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= req_write ? req_wdata : m_data;
                            stat_hit  <= 1'b1;
                        end else begin
                            state_q <= ST_VSRCH;
                        end
                    end
                end
                ST_VSRCH: begin
                    if (v_hit) begin
                        rsp_valid     <= 1'b1;
                        rsp_rdata     <= mw_data;
                        stat_slow_hit <= 1'b1;
                        state_q       <= ST_IDLE;
                    end else if (m_valid && v_ptr_valid && v_ptr_dirty) begin
                        state_q <= ST_WB;
                    end else begin
                        state_q <= ST_RD;
                    end
                end
                ST_WB:   if (mem_req_ready) state_q <= ST_RD;
                ST_RD:   if (mem_req_ready) state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= mw_data;
                        stat_miss <= 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req_valid = (state_q == ST_WB) || (state_q == ST_RD);
    assign mem_req_write = (state_q == ST_WB);
    assign mem_req_addr  = (state_q == ST_WB) ? v_ptr_addr : addr_q;
    assign mem_req_wdata = v_ptr_data;

    // Records that the write-back of the current miss has been accepted
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE) wb_done_q <= 1'b0;
        else if (state_q == ST_WB && mem_req_ready) wb_done_q <= 1'b1;
    end

    assert_hit_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && main_hit) |=> (rsp_valid && stat_hit));

    assert_search_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !main_hit) |=> (!rsp_valid && !mem_req_valid));

    assert_slow_hit_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VSRCH && v_hit) |=> (rsp_valid && stat_slow_hit));

    assert_refill_answer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && mem_rsp_valid) |=> (rsp_valid && stat_miss));

    assert_wb_before_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD && m_valid && v_ptr_valid && v_ptr_dirty) |-> wb_done_q);

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata)));

    assert_status_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({stat_hit, stat_slow_hit, stat_miss}));

    assert_status_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ({stat_hit, stat_slow_hit, stat_miss} == 3'b000));

endmodule

// File: tb/vcache_top_bench.sv
`timescale 1ns/1ps
module vcache_top_bench;

    localparam int ADDR_W  = 10;
    localparam int DATA_W  = 32;
    localparam int SETS    = 8;
    localparam int VICTIMS = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready, rsp_valid, stat_hit, stat_slow_hit, stat_miss;
    logic [DATA_W-1:0] rsp_rdata;
    logic              mem_req_valid, mem_req_write;
    logic              mem_req_ready = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [DATA_W-1:0] mem_req_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_rdata = '0;

    vcache_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .VICTIMS(VICTIMS))
    u_vcache_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .stat_hit(stat_hit),
        .stat_slow_hit(stat_slow_hit), .stat_miss(stat_miss),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    always #2 clk = ~clk;

    int n_checks = 0, n_errors = 0;
    bit done = 1'b0;

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] mem [int];
    bit          mv [SETS];
    bit          md [SETS];
    int          mt [SETS];
    logic [31:0] mdat [SETS];
    bit          vv [VICTIMS];
    bit          vd [VICTIMS];
    int          va [VICTIMS];
    logic [31:0] vdat [VICTIMS];
    int          vptr = 0;
    int          q_wb_addr [$];
    logic [31:0] q_wb_data [$];

    function automatic logic [31:0] mem_rd(input int a);
        if (mem.exists(a)) return mem[a];
        return (a * 32'h0100_0193) ^ 32'hC0DE_0000;
    endfunction

    // kind: 0 fast hit, 1 slow hit, 2 miss
    function automatic void model(input bit w, input int a, input logic [31:0] wd,
                                  output int kind, output logic [31:0] rd);
        int idx = a % SETS;
        int tag = a / SETS;
        int found = -1;
        bit ov = mv[idx]; bit od = md[idx];
        int oa = mt[idx] * SETS + idx;
        logic [31:0] odat = mdat[idx];
        if (mv[idx] && mt[idx] == tag) begin
            kind = 0;
            if (w) begin mdat[idx] = wd; md[idx] = 1'b1; end
            rd = mdat[idx];
            return;
        end
        for (int i = 0; i < VICTIMS; i++) if (vv[i] && va[i] == a) found = i;
        if (found >= 0) begin
            kind = 1;
            mdat[idx] = w ? wd : vdat[found];
            md[idx] = vd[found] | w;
            vv[found] = ov; va[found] = oa; vdat[found] = odat; vd[found] = od;
        end else begin
            kind = 2;
            if (ov) begin
                if (vv[vptr] && vd[vptr]) begin
                    q_wb_addr.push_back(va[vptr]);
                    q_wb_data.push_back(vdat[vptr]);
                end
                vv[vptr] = 1'b1; va[vptr] = oa; vdat[vptr] = odat; vd[vptr] = od;
                vptr = (vptr + 1) % VICTIMS;
            end
            mdat[idx] = w ? wd : mem_rd(a);
            md[idx] = w;
        end
        mv[idx] = 1'b1; mt[idx] = tag;
        rd = mdat[idx];
    endfunction

    // ---------------- next-level memory model ----------------
    int m_wait = 0, rsp_cnt = 0, rd_addr = 0, hold_addr = 0, m_addr = 0;
    bit m_wr = 1'b0;
    logic [31:0] m_wd = '0;
    int n_rd = 0, n_wr = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            mem_rsp_valid = 1'b0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = mem_rd(rd_addr);
                end
            end
            if (mem_req_ready) begin
                mem_req_ready = 1'b0;
                m_wait = 0;
                if (m_wr) begin
                    n_wr++;
                    if (q_wb_addr.size() == 0) begin
                        check_eq("R7", "unexpected write-back addr", 32'(m_addr), 32'hFFFF_FFFF);
                    end else begin
                        check_eq("R7", "write-back addr", 32'(m_addr), 32'(q_wb_addr.pop_front()));
                        check_eq("R7", "write-back data", m_wd, q_wb_data.pop_front());
                    end
                    mem[m_addr] = m_wd;
                end else begin
                    n_rd++;
                    rd_addr = m_addr;
                    rsp_cnt = 2;
                end
            end else if (mem_req_valid) begin
                if (m_wait > 0) check_eq("R8", "held request addr", 32'(mem_req_addr), 32'(hold_addr));
                hold_addr = int'(mem_req_addr);
                if (m_wait == 2) begin
                    mem_req_ready = 1'b1;
                    m_addr = int'(mem_req_addr);
                    m_wr = mem_req_write;
                    m_wd = mem_req_wdata;
                end
                m_wait++;
            end
        end
    end

    // Per-cycle status-flag comparison
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid)
                check_eq("R9", "flag count", 32'($countones({stat_hit, stat_slow_hit, stat_miss})), 32'd1);
            else
                check_eq("R9", "idle flags", 32'({stat_hit, stat_slow_hit, stat_miss}), 32'd0);
        end
    end

    task automatic access(input bit w, input int a, input logic [31:0] wd, input string dreq);
        int kind; int lat; int rd0; int wr0;
        logic [31:0] erd;
        string kreq;
        model(w, a, wd, kind, erd);
        kreq = (kind == 0) ? "R2" : (kind == 1) ? "R3" : "R5";
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd0 = n_rd; wr0 = n_wr;
        req_valid = 1'b1; req_write = w; req_addr = a[ADDR_W-1:0]; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 200) begin @(negedge clk); lat++; end
        check_eq(kreq, "status flags", 32'({stat_hit, stat_slow_hit, stat_miss}),
                 (kind == 0) ? 32'd4 : (kind == 1) ? 32'd2 : 32'd1);
        if (kind == 0) check_eq("R2", "latency", 32'(lat), 32'd1);
        else if (kind == 1) check_eq("R3", "latency", 32'(lat), 32'd2);
        else check_eq("R5", "latency above two", 32'(lat > 2), 32'd1);
        check_eq(dreq, "response data", rsp_rdata, erd);
        check_eq(kreq, "memory reads", 32'(n_rd - rd0), (kind == 2) ? 32'd1 : 32'd0);
        if (kind != 2) check_eq(kreq, "memory writes", 32'(n_wr - wr0), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL R5 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < SETS; i++) begin mv[i] = 0; md[i] = 0; mt[i] = 0; mdat[i] = '0; end
        for (int i = 0; i < VICTIMS; i++) begin vv[i] = 0; vd[i] = 0; va[i] = 0; vdat[i] = '0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "req_ready after reset", 32'(req_ready), 32'd1);
        check_eq("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check_eq("R1", "mem_req_valid after reset", 32'(mem_req_valid), 32'd0);

        // Cold miss, hit, write hit, read-back (R1, R2, R10)
        access(0, 'h010, '0, "R1");
        access(0, 'h010, '0, "R2");
        access(1, 'h010, 32'hA5A5_0001, "R10");
        access(0, 'h010, '0, "R10");
        // Conflict in set 0, then swaps back and forth (R4)
        access(0, 'h018, '0, "R5");
        access(0, 'h010, '0, "R4");
        access(0, 'h018, '0, "R4");
        access(0, 'h010, '0, "R4");
        // Write-allocate on miss
        access(1, 'h020, 32'h1234_5678, "R10");
        access(0, 'h020, '0, "R10");
        // Conflict chain in set 1: rotation and dirty push-out (R6, R7)
        access(1, 'h001, 32'hD00D_0001, "R6");
        access(0, 'h009, '0, "R6");
        access(1, 'h011, 32'hD00D_0011, "R6");
        access(0, 'h019, '0, "R6");
        access(0, 'h021, '0, "R6");
        access(0, 'h029, '0, "R6");
        access(0, 'h031, '0, "R6");
        access(0, 'h039, '0, "R6");
        access(0, 'h001, '0, "R7");
        access(0, 'h011, '0, "R7");
        access(0, 'h009, '0, "R6");

        // Mixed traffic over a few conflicting sets
        for (int n = 0; n < 400; n++) begin
            int a = int'($urandom % 48);
            bit w = ($urandom % 3) == 0;
            access(w, a, $urandom, "R10");
        end
        repeat (10) @(negedge clk);
        check_eq("R7", "pending write-backs", 32'(q_wb_addr.size()), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule